// File: doc/BRIEF.md
# Serial Byte Command Decoder

This block sits between a UART receiver/transmitter pair and a byte-wide synchronous single-port memory. It reads framed commands from the received byte stream and turns them into memory accesses. A header byte carries a direction flag and a 7-bit target ID. Two address bytes follow. Write data then streams straight in. A read instead carries one count byte and gets that many bytes back on the transmit stream.

Several targets may share one serial link, and each decoder answers only to its own ID. Frames that do not match are swallowed. Frame boundaries come from an external frame-idle indication, for example a receive-gap detector. That indication ends open-ended write streams and discards half-received headers. Reads hand one byte at a time to the transmitter, so reply data survives any amount of transmit backpressure.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After reset, `rx_ready_o` is 1, `tx_valid_o` is 0 and `mem_en_o` is 0.
- R2: The first byte of a frame is the command. Bit 7 set means read and clear means write. Bits 6:0 are the target ID. The next two bytes form a 16-bit address, high byte first. Only the low `ADDR_W` bits select a memory location, and the upper bits are ignored.
- R3: In a write frame, each data byte accepted after the address is written to memory as one write strobe. The first byte goes to the start address and each later byte to the next address. The stream continues until `frame_idle_i` is asserted, and a memory write happens only in a cycle where a byte is accepted.
- R4: In a read frame, the fourth byte N (1..255) makes the block return N bytes on the transmit stream. These are the memory contents from the start address upward, in address order. Each fetch is a single read strobe, and its byte appears on `tx_valid_o` two cycles later.
- R5: The address advances by one after every byte written or read, and wraps modulo 2^`ADDR_W`.
- R6: A frame whose ID differs from `TARGET_ID` is accepted byte by byte until `frame_idle_i`. It writes nothing to memory and sends nothing.
- R7: A read count of 0 sends no bytes, and the next byte is decoded as a new command.
- R8: While `tx_valid_o` is 1 and `tx_ready_i` is 0, `tx_valid_o` stays 1 and `tx_data_o` stays unchanged. No read byte is lost.
- R9: `frame_idle_i` during a partly received header (address or count bytes pending) drops that header. The next byte is decoded as a command.
- R10: While a read reply is in progress, `rx_ready_o` is 0, so incoming bytes wait.
- R11: `frame_idle_i` while waiting for a command byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Decoder accepts received byte |
| frame_idle_i | input | 1 | Link idle, frame boundary |
| tx_data_o | output | 8 | Reply byte |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_ready_i | input | 1 | Transmitter accepts reply byte |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after a read strobe |

## Verification
The bench builds the decoder with `ADDR_W` = 12 and `TARGET_ID` = 0x2A, attached to a 4096-byte behavioural memory. With a full 12-bit space, a start address of 0xFFD walks a burst across the wrap to address 0. A start address such as 0xF123 shows that the upper address bits are dropped. The fixed ID lets the bench interleave frames addressed to ID 0x15, whose writes must leave the memory untouched and whose reads must produce no reply. A repeating stall pattern on `tx_ready_i` exercises the reply path under backpressure.

// File: rtl/scd_pkg.sv
package scd_pkg;
  typedef enum logic [3:0] {
    ST_CMD,
    ST_ADR_HI,
    ST_ADR_LO,
    ST_COUNT,
    ST_WRITE,
    ST_SKIP,
    ST_FETCH,
    ST_LATCH,
    ST_SEND
  } scd_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ID_W   = 7;
endpackage

// File: rtl/scd_addr_ctr.sv
module scd_addr_ctr #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic              inc_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned FULL_W = 16;

  logic [7:0]        hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic [FULL_W-1:0] full_addr;

  assign full_addr = {hi_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      if (ld_hi_i) hi_q <= byte_i;
      if (ld_lo_i)      addr_q <= full_addr[ADDR_W-1:0];
      else if (inc_i)   addr_q <= addr_q + 1'b1;  // wraps at 2^ADDR_W
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/scd_burst_ctr.sv
module scd_burst_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= cnt_i;
    else if (dec_i)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/scd_tx_hold.sv
module scd_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              sent_o
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign sent_o = vld_q & tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (cap_i) begin
      vld_q <= 1'b1;
      dat_q <= data_i;
    end else if (sent_o) begin
      vld_q <= 1'b0;
    end
  end

  assign tx_valid_o = vld_q;
  assign tx_data_o  = dat_q;
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
  import scd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [6:0]  TARGET_ID = 7'h2A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic              frame_idle_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int unsigned CNT_W = BYTE_W;

  scd_state_e state_q, state_d;
  logic       is_rd_q, is_rd_d;
  logic       rx_fire, in_frame, abort;
  logic       ld_hi, ld_lo, adr_inc, cnt_load, cnt_dec, cnt_zero;
  logic       tx_cap, tx_sent, wr_fire;
  logic [ADDR_W-1:0] addr;

  assign rx_ready_o = (state_q == ST_CMD)    || (state_q == ST_ADR_HI) ||
                      (state_q == ST_ADR_LO) || (state_q == ST_COUNT)  ||
                      (state_q == ST_WRITE)  || (state_q == ST_SKIP);
  assign rx_fire    = rx_valid_i & rx_ready_o;
  // frame_idle only matters once a frame has started
  assign in_frame   = rx_ready_o && (state_q != ST_CMD);
  assign abort      = frame_idle_i & in_frame;
  assign wr_fire    = (state_q == ST_WRITE) & rx_fire & ~frame_idle_i;

  always_comb begin
    state_d  = state_q;
    is_rd_d  = is_rd_q;
    ld_hi    = 1'b0;
    ld_lo    = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    tx_cap   = 1'b0;
    adr_inc  = 1'b0;
    if (abort) begin
      state_d = ST_CMD;
    end else begin
      unique case (state_q)
        ST_CMD: if (rx_fire) begin
          is_rd_d = rx_data_i[7];
          state_d = (rx_data_i[6:0] == TARGET_ID) ? ST_ADR_HI : ST_SKIP;
        end
        ST_ADR_HI: if (rx_fire) begin
          ld_hi   = 1'b1;
          state_d = ST_ADR_LO;
        end
        ST_ADR_LO: if (rx_fire) begin
          ld_lo   = 1'b1;
          state_d = is_rd_q ? ST_COUNT : ST_WRITE;
        end
        ST_COUNT: if (rx_fire) begin
          cnt_load = 1'b1;
          state_d  = (rx_data_i == 8'd0) ? ST_CMD : ST_FETCH;
        end
        ST_WRITE: adr_inc = wr_fire;
        ST_SKIP:  ;
        ST_FETCH: state_d = ST_LATCH;
        ST_LATCH: begin
          tx_cap  = 1'b1;
          adr_inc = 1'b1;
          cnt_dec = 1'b1;
          state_d = ST_SEND;
        end
        ST_SEND: if (tx_sent) state_d = cnt_zero ? ST_CMD : ST_FETCH;
        default: state_d = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      is_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      is_rd_q <= is_rd_d;
    end
  end

  scd_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_hi_i(ld_hi),
    .ld_lo_i(ld_lo),
    .inc_i  (adr_inc),
    .byte_i (rx_data_i),
    .addr_o (addr)
  );

  scd_burst_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .dec_i  (cnt_dec),
    .cnt_i  (rx_data_i),
    .zero_o (cnt_zero)
  );

  scd_tx_hold #(.DATA_W(BYTE_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (tx_cap),
    .data_i    (mem_rdata_i),
    .tx_ready_i(tx_ready_i),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o),
    .sent_o    (tx_sent)
  );

  assign mem_en_o    = wr_fire | (state_q == ST_FETCH);
  assign mem_we_o    = wr_fire;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = rx_data_i;
endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [7:0]        tx_data_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  // R3
  wr_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (rx_valid_i && rx_ready_o && mem_en_o));

  // R5
  wr_addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

  // R4
  rd_to_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_we_o) |=> (!mem_en_o ##1 tx_valid_o));

  // R8
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R10
  rx_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !rx_ready_o);
endmodule

bind serial_cmd_decoder scd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_valid_i(rx_valid_i),
  .rx_ready_o(rx_ready_o),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .tx_data_o (tx_data_o),
  .mem_en_o  (mem_en_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/sim_serial_cmd_decoder.sv
module sim_serial_cmd_decoder;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam logic [6:0]  MY_ID  = 7'h2A;
  localparam logic [6:0]  NO_ID  = 7'h15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, frame_idle = 1'b0, tx_ready = 1'b0;
  logic rx_ready, tx_valid, mem_en, mem_we;
  logic [7:0] tx_data, mem_wdata, mem_rdata;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] ram [DEPTH];
  logic [7:0] shadow [DEPTH];

  always #10 clk = ~clk;

  serial_cmd_decoder #(.ADDR_W(ADDR_W), .TARGET_ID(MY_ID)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .frame_idle_i(frame_idle), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .mem_en_o(mem_en),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: stall pattern on tx_ready, compare each accepted byte
  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = (cyc % 5 != 2) && (cyc % 7 != 3);
      if (rst_n && tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected tx byte", int'(tx_data), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(tx_data == e, "R4 R8 reply byte", int'(tx_data), int'(e));
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_idle();
    @(negedge clk);
    frame_idle = 1'b1;
    @(negedge clk);
    frame_idle = 1'b0;
  endtask

  task automatic wait_drain(input string tag);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !tx_valid, tag, exp_q.size(), 0);
  endtask

  task automatic wr_frame(input logic [6:0] id, input logic [15:0] a, input int n,
                          input logic [7:0] seed);
    send_byte({1'b0, id});
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed + 8'(i * 13);
      send_byte(d);
      if (id == MY_ID) shadow[(int'(a) + i) % DEPTH] = d;
    end
    pulse_idle();
  endtask

  task automatic rd_frame(input logic [6:0] id, input logic [15:0] a, input int n,
                          input string tag);
    if (id == MY_ID)
      for (int i = 0; i < n; i++) exp_q.push_back(shadow[(int'(a) + i) % DEPTH]);
    send_byte({1'b1, id});
    send_byte(a[15:8]);
    send_byte(a[7:0]);
    send_byte(8'(n));
    if (id == MY_ID && n > 0) begin
      while (!tx_valid) @(negedge clk);
      // R10: a waiting byte is not taken during the reply
      chk(!rx_ready, "R10 rx held during reply", int'(rx_ready), 0);
    end
    if (id != MY_ID) pulse_idle();
    wait_drain(tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram[i]    = 8'((i * 37 + 5) & 8'hFF);
      shadow[i] = 8'((i * 37 + 5) & 8'hFF);
    end
    repeat (3) @(negedge clk);
    // R1
    chk(rx_ready == 1'b1, "R1 rx_ready in reset", int'(rx_ready), 1);
    chk(tx_valid == 1'b0, "R1 tx_valid in reset", int'(tx_valid), 0);
    chk(mem_en == 1'b0, "R1 mem_en in reset", int'(mem_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready && !tx_valid && !mem_en, "R1 after reset", int'({rx_ready, tx_valid, mem_en}), 4);

    // R3 R4: stream write then burst read under backpressure (R8)
    wr_frame(MY_ID, 16'h0010, 8, 8'h40);
    rd_frame(MY_ID, 16'h0010, 8, "R3 R4 burst readback");

    // R2: upper address bits ignored
    wr_frame(MY_ID, 16'hF123, 3, 8'hA0);
    rd_frame(MY_ID, 16'h0123, 3, "R2 high bits dropped");

    // R5: wrap across top of memory
    wr_frame(MY_ID, 16'h0FFD, 6, 8'h11);
    rd_frame(MY_ID, 16'h0FFD, 6, "R5 wrap readback");

    // R6: foreign write discarded, foreign read silent
    wr_frame(NO_ID, 16'h0010, 4, 8'hEE);
    rd_frame(NO_ID, 16'h0010, 4, "R6 foreign read silent");
    rd_frame(MY_ID, 16'h0010, 4, "R6 memory untouched");

    // R7: zero count
    rd_frame(MY_ID, 16'h0200, 0, "R7 zero count silent");
    chk(rx_ready == 1'b1, "R7 ready for new command", int'(rx_ready), 1);
    rd_frame(MY_ID, 16'h0200, 2, "R7 next frame decoded");

    // R9: truncated header dropped
    send_byte({1'b1, MY_ID});
    send_byte(8'h03);
    pulse_idle();
    rd_frame(MY_ID, 16'h0FFE, 3, "R9 after aborted header");

    // R11: idle while waiting for command
    pulse_idle();
    pulse_idle();
    rd_frame(MY_ID, 16'h0014, 5, "R11 idle in command wait");

    // long burst with stalls (R8)
    wr_frame(MY_ID, 16'h0300, 20, 8'h07);
    rd_frame(MY_ID, 16'h0300, 20, "R8 long burst");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule